// File: doc/BRIEF.md
# Limit-Monitor Interrupt Aggregator

This block takes conversion results from a periodic analog and temperature monitor and merges them with fan and GPIO event lines into a single active-low interrupt. Each result arrives with a channel index. It is compared against that channel's programmable upper and lower bounds. The outcome is written into a per-channel status bit, and a per-channel mask gates that bit. The unmasked status bits are ORed together, and the OR sets a sticky analog interrupt latch. Fan and GPIO events have their own masks and go straight to the output, so they do not pass through the latch.

Software clears the analog latch with a one-cycle clear pulse. After a clear, the latch is held off until a fixed number of local-temperature conversions have completed. During that window a status bit that is still set, or a new out-of-limit result, cannot raise the analog interrupt again. Fan and GPIO events can still drive the output low at any time. Limits, masks and status are reached through a simple word-wide register port. Writes are synchronous and reads are combinational.

Top module: `limit_irq_agg`

## Requirements
- R1: A result is out of limit when it is strictly greater than the channel's upper bound. A result equal to the upper bound is in limit.
- R2: A result is also out of limit when it is less than or equal to the channel's lower bound. A result one count above the lower bound is in limit.
- R3: Every valid result overwrites status bit `res_ch` at the next clock edge, with 1 for out of limit and 0 for in limit. A later in-limit result clears a set bit with no software action.
- R4: After reset, all channel, fan and GPIO mask bits are 1, status is 0, every upper bound is 0xFF, every lower bound is 0x00, the latch is clear, no holdoff is running, and `int_n` is 1.
- R5: A mask bit of 1 hides its source from `int_n`, and a mask bit of 0 lets it through. This applies to channel status, fan events and GPIO events.
- R6: When any unmasked status bit is 1 and no holdoff is running, the latch sets one edge later. It then stays set, even if the status clears, until a clear pulse arrives. `int_n` is 0 whenever the latch is set.
- R7: A clear pulse resets the latch at the next edge and leaves every status bit unchanged.
- R8: A clear starts a holdoff. The latch cannot set until 2 valid results with `res_local` = 1 have been accepted after the clear. Results with `res_local` = 0 do not advance the holdoff. The latch may set on the edge after the second local result.
- R9: An unmasked, active fan or GPIO event drives `int_n` to 0 in the same cycle, including during a holdoff. `int_n` returns to 1 when the event drops, provided no other source is active.
- R10: Register map, with a 7-bit address and 32-bit data:
  - 0..31: upper bound of channel n, in bits 7:0.
  - 32..63: lower bound of channel n-32, in bits 7:0.
  - 64: channel mask.
  - 65: status, read-only.
  - 66: fan mask in bits 7:0 and GPIO mask in bits 15:8.
  - Any other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld | input | 1 | Conversion result strobe |
| res_ch | input | 5 | Channel index of the result |
| res_val | input | 8 | Conversion value |
| res_local | input | 1 | Result is a local-temperature conversion |
| fan_evt | input | 8 | Fan event lines, level, active high |
| gpio_evt | input | 8 | GPIO event lines, level, active high |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| int_clr | input | 1 | One-cycle clear of the analog latch |
| int_n | output | 1 | Combined interrupt, active low |

## Verification
The hardest state to reach from the ports is a holdoff window that is partly used up while the analog cause is still present. To build it, the stimulus first latches an interrupt from an unmasked channel and re-sets that channel's status bit. It then clears the latch and keeps the channel out of limit with non-local results, which must not advance the count. A single local result follows. Only then are fan and GPIO events pulsed: they must pull `int_n` low at once while the analog latch stays blocked. The second local result is timed so that the bench checks `int_n` both on the edge that ends the holdoff and on the edge after it.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int unsigned CH_W   = 5;
  localparam int unsigned NUM_CH = 1 << CH_W;
  localparam int unsigned ADDR_W = CH_W + 2;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    RG_HI, RG_LO, RG_CMASK, RG_STAT, RG_EMASK, RG_NONE
  } reg_sel_e;

  // Upper half of the map holds the single-word registers.
  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    if (!a[ADDR_W-1]) s = a[ADDR_W-2] ? RG_LO : RG_HI;
    else begin
      case (a[ADDR_W-2:0])
        (ADDR_W-1)'(0): s = RG_CMASK;
        (ADDR_W-1)'(1): s = RG_STAT;
        (ADDR_W-1)'(2): s = RG_EMASK;
        default:        s = RG_NONE;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned NUM_FAN  = 8,
  parameter int unsigned NUM_GPIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [CH_W-1:0]   sel_ch,
  input  logic [NUM_CH-1:0] status,
  output logic [DW-1:0]     hi_sel,
  output logic [DW-1:0]     lo_sel,
  output logic [NUM_CH-1:0] ch_mask,
  output logic [NUM_FAN-1:0]  fan_mask,
  output logic [NUM_GPIO-1:0] gpio_mask,
  output logic [NUM_CH-1:0] rdata
);
  logic [DW-1:0] hi_lim [NUM_CH];
  logic [DW-1:0] lo_lim [NUM_CH];
  reg_sel_e      sel;

  assign sel = decode_addr(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        hi_lim[i] <= '1;
        lo_lim[i] <= '0;
      end
      ch_mask   <= '1;
      fan_mask  <= '1;
      gpio_mask <= '1;
    end else if (wr_en) begin
      case (sel)
        RG_HI:    hi_lim[addr[CH_W-1:0]] <= wdata[DW-1:0];
        RG_LO:    lo_lim[addr[CH_W-1:0]] <= wdata[DW-1:0];
        RG_CMASK: ch_mask <= wdata;
        RG_EMASK: begin
          fan_mask  <= wdata[NUM_FAN-1:0];
          gpio_mask <= wdata[NUM_FAN +: NUM_GPIO];
        end
        default: ;
      endcase
    end
  end

  assign hi_sel = hi_lim[sel_ch];
  assign lo_sel = lo_lim[sel_ch];

  always_comb begin
    rdata = '0;
    case (sel)
      RG_HI:    rdata[DW-1:0] = hi_lim[addr[CH_W-1:0]];
      RG_LO:    rdata[DW-1:0] = lo_lim[addr[CH_W-1:0]];
      RG_CMASK: rdata = ch_mask;
      RG_STAT:  rdata = status;
      RG_EMASK: begin
        rdata[NUM_FAN-1:0]         = fan_mask;
        rdata[NUM_FAN +: NUM_GPIO] = gpio_mask;
      end
      default: rdata = '0;
    endcase
  end

  // R10: a write to the channel mask is visible on the next cycle
  p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RG_CMASK) |=> ch_mask == $past(wdata));
endmodule

// File: rtl/lirq_compare.sv
module lirq_compare
  import lirq_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_vld,
  input  logic [CH_W-1:0]   res_ch,
  input  logic [DW-1:0]     res_val,
  input  logic [DW-1:0]     hi_sel,
  input  logic [DW-1:0]     lo_sel,
  output logic              oor,
  output logic [NUM_CH-1:0] status
);
  // Upper bound is exclusive, lower bound is inclusive.
  function automatic logic beyond_limits(input logic [DW-1:0] v,
                                         input logic [DW-1:0] hi,
                                         input logic [DW-1:0] lo);
    return (v > hi) || (v <= lo);
  endfunction

  assign oor = beyond_limits(res_val, hi_sel, lo_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else if (res_vld) status[res_ch] <= oor;
  end

  // R3: each valid result overwrites exactly its own channel's bit
  p_status_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> status[$past(res_ch)] == $past(oor));
  // R3: status is untouched when no result arrives
  p_status_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |=> $stable(status));
endmodule

// File: rtl/lirq_holdoff.sv
module lirq_holdoff #(
  parameter int unsigned HOLDOFF_N = 2,
  localparam int unsigned CW = $clog2(HOLDOFF_N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic clr,
  input  logic local_tick,
  output logic latch,
  output logic hold_active
);
  logic [CW-1:0] cnt;

  assign hold_active = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= 1'b0;
      cnt   <= '0;
    end else if (clr) begin
      latch <= 1'b0;
      cnt   <= CW'(HOLDOFF_N);
    end else begin
      if (local_tick && hold_active) cnt <= cnt - 1'b1;
      if (pending && !hold_active)   latch <= 1'b1;
    end
  end

  // R7: a clear empties the latch
  p_clear_resets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !latch);
  // R8: the latch stays empty while the holdoff runs
  p_holdoff_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !latch);
  // R8: the count only moves on a local conversion
  p_holdoff_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !local_tick) |=> $stable(cnt));
  // R6: the latch is sticky until cleared
  p_latch_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !clr) |=> latch);
endmodule

// File: rtl/limit_irq_agg.sv
module limit_irq_agg
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_FAN   = 8,
  parameter int unsigned NUM_GPIO  = 8,
  parameter int unsigned HOLDOFF_N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                res_vld,
  input  logic [CH_W-1:0]     res_ch,
  input  logic [DATA_W-1:0]   res_val,
  input  logic                res_local,
  input  logic [NUM_FAN-1:0]  fan_evt,
  input  logic [NUM_GPIO-1:0] gpio_evt,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NUM_CH-1:0]   reg_wdata,
  output logic [NUM_CH-1:0]   reg_rdata,
  input  logic                int_clr,
  output logic                int_n
);
  logic [DATA_W-1:0]   hi_sel, lo_sel;
  logic [NUM_CH-1:0]   ch_mask, status;
  logic [NUM_FAN-1:0]  fan_mask;
  logic [NUM_GPIO-1:0] gpio_mask;
  logic                oor, pending, side_evt, latch, hold_active;

  lirq_regs #(.DW(DATA_W), .NUM_FAN(NUM_FAN), .NUM_GPIO(NUM_GPIO)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .sel_ch(res_ch), .status(status),
    .hi_sel(hi_sel), .lo_sel(lo_sel), .ch_mask(ch_mask),
    .fan_mask(fan_mask), .gpio_mask(gpio_mask), .rdata(reg_rdata));

  lirq_compare #(.DW(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_ch(res_ch),
    .res_val(res_val), .hi_sel(hi_sel), .lo_sel(lo_sel),
    .oor(oor), .status(status));

  assign pending  = |(status & ~ch_mask);
  assign side_evt = (|(fan_evt & ~fan_mask)) | (|(gpio_evt & ~gpio_mask));

  lirq_holdoff #(.HOLDOFF_N(HOLDOFF_N)) u_hold (
    .clk(clk), .rst_n(rst_n), .pending(pending), .clr(int_clr),
    .local_tick(res_vld & res_local), .latch(latch),
    .hold_active(hold_active));

  assign int_n = ~(latch | side_evt);

  // R7: a clear leaves status alone when no result arrives with it
  p_clear_keeps_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr && !res_vld) |=> $stable(status));
  // R9: side events reach the pin during a holdoff
  p_side_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && side_evt) |-> !int_n);
  // R6: an unmasked pending bit outside holdoff latches on the next edge
  p_pending_latches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !hold_active && !int_clr) |=> (latch && !int_n));
endmodule

// File: tb/test_limit_irq_agg.sv
module test_limit_irq_agg;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [6:0] A_CMASK = 7'd64, A_STAT = 7'd65, A_EMASK = 7'd66;
  // {value, expected status} for channel 3 with upper 0xA0, lower 0x20
  localparam logic [8:0] VEC [10] = '{
    {8'hA0, 1'b0}, {8'hA1, 1'b1}, {8'h9F, 1'b0}, {8'hFF, 1'b1},
    {8'h20, 1'b1}, {8'h21, 1'b0}, {8'h1F, 1'b1}, {8'h50, 1'b0},
    {8'h00, 1'b1}, {8'hF0, 1'b1}};

  logic clk = 0, rst_n = 0;
  logic res_vld = 0, res_local = 0, reg_wr = 0, int_clr = 0;
  logic [4:0] res_ch = '0;
  logic [7:0] res_val = '0, fan_evt = '0, gpio_evt = '0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic int_n;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  limit_irq_agg i_limit_irq_agg (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_ch(res_ch),
    .res_val(res_val), .res_local(res_local), .fan_evt(fan_evt),
    .gpio_evt(gpio_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_clr(int_clr),
    .int_n(int_n));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic strobe(input logic [4:0] ch, input logic [7:0] v, input logic loc);
    @(negedge clk); res_vld = 1; res_ch = ch; res_val = v; res_local = loc;
    @(negedge clk); res_vld = 0; res_local = 0;
  endtask

  task automatic clear_pulse();
    @(negedge clk); int_clr = 1;
    @(negedge clk); int_clr = 0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4: reset state
    chk(int_n, 1, "R4 int_n");
    rd(A_STAT, d);  chk(d, 32'h0, "R4 status");
    rd(A_CMASK, d); chk(d, 32'hFFFF_FFFF, "R4 chmask");
    rd(A_EMASK, d); chk(d, 32'h0000_FFFF, "R4 evmask");
    rd(7'd9, d);    chk(d, 32'hFF, "R4 upper");
    rd(7'd41, d);   chk(d, 32'h0, "R4 lower");
    // R10: map
    wr(7'd3, 32'hA0); wr(7'd35, 32'h20);
    rd(7'd3, d);  chk(d, 32'hA0, "R10 upper ch3");
    rd(7'd35, d); chk(d, 32'h20, "R10 lower ch3");
    rd(7'd99, d); chk(d, 32'h0, "R10 unmapped");

    // R1 R2 R3: boundary table on channel 3, all masked
    foreach (VEC[i]) begin
      strobe(5'd3, VEC[i][8:1], 1'b0);
      rd(A_STAT, d);
      chk(d[3], VEC[i][0], $sformatf("R1/R2/R3 val=%0h", VEC[i][8:1]));
    end
    rd(A_STAT, d); chk(d, 32'h8, "R3 other bits untouched");
    @(negedge clk);
    chk(int_n, 1, "R5 masked status hidden");

    // R6: unmask ch3 -> latch one edge after mask lands
    wr(A_CMASK, ~32'h8);
    chk(int_n, 1, "R6 not yet latched");
    @(negedge clk);
    chk(int_n, 0, "R6 latched");
    strobe(5'd3, 8'h50, 1'b0);
    rd(A_STAT, d); chk(d[3], 0, "R3 self clear");
    chk(int_n, 0, "R6 sticky after status clears");
    strobe(5'd3, 8'hF0, 1'b0);

    // R7: clear
    clear_pulse();
    chk(int_n, 1, "R7 latch cleared");
    rd(A_STAT, d); chk(d[3], 1, "R7 status kept");

    // R8: holdoff, non-local results do not count
    repeat (3) strobe(5'd3, 8'hF0, 1'b0);
    @(negedge clk);
    chk(int_n, 1, "R8 non-local ignored");
    strobe(5'd0, 8'h40, 1'b1);
    @(negedge clk);
    chk(int_n, 1, "R8 one local");

    // R9 and R5: fan/GPIO during holdoff
    wr(A_EMASK, 32'hFFFF_FEFE);
    fan_evt = 8'h02; #1; chk(int_n, 1, "R5 masked fan");
    fan_evt = 8'h01; #1; chk(int_n, 0, "R9 fan bypass");
    fan_evt = 8'h00; #1; chk(int_n, 1, "R9 fan drop");
    gpio_evt = 8'h01; #1; chk(int_n, 0, "R9 gpio bypass");
    gpio_evt = 8'h00; #1; chk(int_n, 1, "R9 gpio drop");

    // R8: second local result ends holdoff, latch on the following edge
    strobe(5'd0, 8'h40, 1'b1);
    chk(int_n, 1, "R8 edge ending holdoff");
    @(negedge clk);
    chk(int_n, 0, "R8 relatched after two locals");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule